// File: doc/BRIEF.md
# Programmable Memory Pattern Sequencer

This block produces the control waveforms of external memory cycles from a small program held in a writable pattern store of 64 words of 32 bits each. Rather than a fixed state machine, each request type enters the store at its own fixed address. From there the sequencer executes one word per clock. Every word it executes drives a group of general-purpose control lines, a byte-select group and a chip-select group for that cycle. A flag bit in the word ends the pattern.

There are four sources that start a pattern. Memory access requests use four entry points, one per access kind. A refresh request has its own entry point. A host run command starts at any address it names. A bus-timeout event aborts whatever pattern is running and jumps to the exception entry point. A word can also enable waiting. When it does, an external wait line, brought in through a two-flop synchronizer, freezes the sequencer on that word for as long as the line stays high. The host loads the store through a plain address/data/write-enable port, but only while the sequencer is idle.

States:
- `ST_IDLE`: no pattern is running.
- `ST_RUN`: a word is executing.
- `ST_FROZEN`: the current word is held by the wait line.

Transitions:
- start: `ST_IDLE` to `ST_RUN`.
- step: `ST_RUN` or `ST_FROZEN` to `ST_RUN`, moving to the next word.
- hold: `ST_RUN` or `ST_FROZEN` to `ST_FROZEN`.
- preempt: `ST_RUN` or `ST_FROZEN` to `ST_RUN`, at the exception entry.
- finish: `ST_RUN` or `ST_FROZEN` to `ST_IDLE`, after a word marked last.

Top module: `mem_pattern_seq`

## Requirements
- R1: After reset the sequencer is idle. `busy` and `done` are 0, and the gpl, bsel and csel outputs are all 0.
- R2: When idle and `acc_valid` is high, the clock edge starts a pattern at the address chosen by `acc_kind`: 0 (read single) at 0x00, 1 (read burst) at 0x08, 2 (write single) at 0x18, 3 (write burst) at 0x20. The first word appears on the outputs right after that edge.
- R3: When idle, `refresh_req` starts the refresh pattern at address 0x30.
- R4: When idle, `run_cmd` starts a pattern at `run_addr`, which can be any of the 64 addresses.
- R5: When several start inputs are high in the same idle cycle, refresh wins over a run command, and a run command wins over an access request. Start inputs seen while a pattern is running are dropped and never queued.
- R6: While busy, the outputs show the fields of the executing word: gpl = bits [13:0], bsel = bits [21:14], csel = bits [29:22]. With no wait and no timeout, the next word is the following address, one word per cycle.
- R7: Bit 31 marks a word as last. On the edge after such a word executes, the sequencer goes idle, and `done` is high for exactly that one cycle.
- R8: Bit 30 enables waiting. `wait_in` passes through two flops. While the synchronized value is high and the current word has bit 30 set, the sequencer holds that word and its outputs. A change on `wait_in` first affects the step decision three edges later.
- R9: A `timeout` pulse while busy makes the next edge jump to the exception pattern at 0x3C. A timeout is ignored while idle, and also while the exception pattern itself is running.
- R10: A host write updates the store only if the sequencer is idle in that cycle. Writes issued while busy are discarded.
- R11: Stepping past address 0x3F wraps to 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| acc_valid | input | 1 | Memory access request |
| acc_kind | input | 2 | Access kind: 0 read single, 1 read burst, 2 write single, 3 write burst |
| refresh_req | input | 1 | Refresh pattern request |
| run_cmd | input | 1 | Host run command |
| run_addr | input | 6 | Start address for the run command |
| timeout | input | 1 | Bus-timeout event |
| wait_in | input | 1 | Asynchronous external wait line |
| host_we | input | 1 | Pattern store write enable |
| host_addr | input | 6 | Pattern store write address |
| host_wdata | input | 32 | Pattern store write data |
| gpl | output | 14 | General-purpose control lines |
| bsel | output | 8 | Byte selects |
| csel | output | 8 | Chip selects |
| busy | output | 1 | A pattern is running |
| done | output | 1 | One-cycle pulse after the last word |

## Verification
The embedded properties assume that `timeout` and the start inputs are level samples taken at the clock edge. They also assume that the store is never written during a pattern except in the deliberate case that tests R10. The bench drives every input on the falling edge and writes the store only through its host task, so those conditions hold everywhere else. The store is not reset, so the bench fills all 64 words before it issues any start. This means no executed word is ever unknown. The wait line is raised and lowered well clear of the start edges, so the three-edge latency of R8 can be counted exactly.

// File: rtl/mps_pkg.sv
package mps_pkg;
    localparam int GPL_W   = 14;
    localparam int BS_W    = 8;
    localparam int CS_W    = 8;
    localparam int GPL_LSB = 0;
    localparam int BS_LSB  = GPL_LSB + GPL_W;
    localparam int CS_LSB  = BS_LSB + BS_W;
    localparam int WAIT_B  = CS_LSB + CS_W;
    localparam int LAST_B  = WAIT_B + 1;
    localparam int WORD_W  = LAST_B + 1;

    typedef enum logic [1:0] {
        ACC_RD_SINGLE = 2'd0,
        ACC_RD_BURST  = 2'd1,
        ACC_WR_SINGLE = 2'd2,
        ACC_WR_BURST  = 2'd3
    } acc_kind_e;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_RUN    = 2'd1,
        ST_FROZEN = 2'd2
    } seq_state_e;
endpackage

// File: rtl/mps_pattern_ram.sv
module mps_pattern_ram #(
    parameter int DEPTH = 64,
    parameter int WIDTH = 32,
    localparam int AW   = $clog2(DEPTH)
) (
    input  logic             clk,
    input  logic             we,
    input  logic [AW-1:0]    waddr,
    input  logic [WIDTH-1:0] wdata,
    input  logic [AW-1:0]    raddr,
    output logic [WIDTH-1:0] rdata
);
    logic [WIDTH-1:0] store [DEPTH];

    always_ff @(posedge clk) begin
        if (we) store[waddr] <= wdata;
    end

    assign rdata = store[raddr];
endmodule

// File: rtl/mps_wait_sync.sv
module mps_wait_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    output logic dout
);
    logic [STAGES-1:0] chain;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain <= '0;
        else        chain <= {chain[STAGES-2:0], din};
    end

    assign dout = chain[STAGES-1];
endmodule

// File: rtl/mps_entry_sel.sv
module mps_entry_sel #(
    parameter int AW        = 6,
    parameter int RD1_ENTRY = 'h00,
    parameter int RDB_ENTRY = 'h08,
    parameter int WR1_ENTRY = 'h18,
    parameter int WRB_ENTRY = 'h20,
    parameter int REF_ENTRY = 'h30
) (
    input  logic                refresh_req,
    input  logic                run_cmd,
    input  logic [AW-1:0]       run_addr,
    input  logic                acc_valid,
    input  mps_pkg::acc_kind_e  acc_kind,
    output logic                start,
    output logic [AW-1:0]       start_addr
);
    import mps_pkg::*;

    logic [AW-1:0] acc_entry;

    always_comb begin
        unique case (acc_kind)
            ACC_RD_SINGLE: acc_entry = AW'(RD1_ENTRY);
            ACC_RD_BURST:  acc_entry = AW'(RDB_ENTRY);
            ACC_WR_SINGLE: acc_entry = AW'(WR1_ENTRY);
            ACC_WR_BURST:  acc_entry = AW'(WRB_ENTRY);
            default:       acc_entry = AW'(RD1_ENTRY);
        endcase
    end

    always_comb begin
        start = refresh_req | run_cmd | acc_valid;
        if (refresh_req)  start_addr = AW'(REF_ENTRY);
        else if (run_cmd) start_addr = run_addr;
        else              start_addr = acc_entry;
    end
endmodule

// File: rtl/mem_pattern_seq.sv
module mem_pattern_seq #(
    parameter int DEPTH       = 64,
    parameter int SYNC_STAGES = 2,
    parameter int REF_ENTRY   = 'h30,
    parameter int EXC_ENTRY   = 'h3C,
    localparam int AW         = $clog2(DEPTH),
    localparam int WW         = mps_pkg::WORD_W
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      acc_valid,
    input  logic [1:0]                acc_kind,
    input  logic                      refresh_req,
    input  logic                      run_cmd,
    input  logic [AW-1:0]             run_addr,
    input  logic                      timeout,
    input  logic                      wait_in,
    input  logic                      host_we,
    input  logic [AW-1:0]             host_addr,
    input  logic [WW-1:0]             host_wdata,
    output logic [mps_pkg::GPL_W-1:0] gpl,
    output logic [mps_pkg::BS_W-1:0]  bsel,
    output logic [mps_pkg::CS_W-1:0]  csel,
    output logic                      busy,
    output logic                      done
);
    import mps_pkg::*;

    seq_state_e    state_q, state_d;
    logic [AW-1:0] ptr_q, ptr_d;
    logic [WW-1:0] word_q, ram_rdata;
    logic          load_word;
    logic          in_exc_q, in_exc_d;
    logic          done_d;
    logic          wait_sync;
    logic          start;
    logic [AW-1:0] start_addr;
    logic          ram_we;
    logic          preempt;

    mps_entry_sel #(.AW(AW), .REF_ENTRY(REF_ENTRY)) u_entry (
        .refresh_req (refresh_req),
        .run_cmd     (run_cmd),
        .run_addr    (run_addr),
        .acc_valid   (acc_valid),
        .acc_kind    (acc_kind_e'(acc_kind)),
        .start       (start),
        .start_addr  (start_addr)
    );

    mps_wait_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .din   (wait_in),
        .dout  (wait_sync)
    );

    assign ram_we = host_we && (state_q == ST_IDLE);

    mps_pattern_ram #(.DEPTH(DEPTH), .WIDTH(WW)) u_ram (
        .clk   (clk),
        .we    (ram_we),
        .waddr (host_addr),
        .wdata (host_wdata),
        .raddr (ptr_d),
        .rdata (ram_rdata)
    );

    assign preempt = timeout && !in_exc_q;

    // next-state logic: start, step, hold, preempt, finish
    always_comb begin
        state_d   = state_q;
        ptr_d     = ptr_q;
        in_exc_d  = in_exc_q;
        load_word = 1'b0;
        done_d    = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                if (start) begin
                    state_d   = ST_RUN;
                    ptr_d     = start_addr;
                    load_word = 1'b1;
                    in_exc_d  = 1'b0;
                end
            end
            ST_RUN, ST_FROZEN: begin
                if (preempt) begin
                    state_d   = ST_RUN;
                    ptr_d     = AW'(EXC_ENTRY);
                    load_word = 1'b1;
                    in_exc_d  = 1'b1;
                end else if (word_q[WAIT_B] && wait_sync) begin
                    state_d = ST_FROZEN;
                end else if (word_q[LAST_B]) begin
                    state_d  = ST_IDLE;
                    done_d   = 1'b1;
                    in_exc_d = 1'b0;
                end else begin
                    state_d   = ST_RUN;
                    ptr_d     = ptr_q + 1'b1;
                    load_word = 1'b1;
                end
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q  <= ST_IDLE;
            ptr_q    <= '0;
            word_q   <= '0;
            in_exc_q <= 1'b0;
            done_q_r <= 1'b0;
        end else begin
            state_q  <= state_d;
            ptr_q    <= ptr_d;
            in_exc_q <= in_exc_d;
            done_q_r <= done_d;
            if (load_word) word_q <= ram_rdata;
        end
    end

    logic done_q_r;

    // output logic
    always_comb begin
        busy = (state_q != ST_IDLE);
        done = done_q_r;
        if (busy) begin
            gpl  = word_q[GPL_LSB +: GPL_W];
            bsel = word_q[BS_LSB  +: BS_W];
            csel = word_q[CS_LSB  +: CS_W];
        end else begin
            gpl  = '0;
            bsel = '0;
            csel = '0;
        end
    end

    assert_wait_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && word_q[WAIT_B] && wait_sync && !preempt) |=> ($stable(ptr_q) && $stable(word_q) && busy));

    assert_exc_entry_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && timeout && !in_exc_q) |=> (ptr_q == AW'(EXC_ENTRY) && in_exc_q && busy));

    assert_done_single_R7: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    assert_done_after_busy_R7: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> ($past(busy) && !busy));

    assert_refresh_entry_R3: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(busy) && $past(refresh_req)) |-> (ptr_q == AW'(REF_ENTRY)));

    assert_run_entry_R4: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(busy) && $past(run_cmd && !refresh_req)) |-> (ptr_q == $past(run_addr)));
endmodule

// File: tb/tb_mem_pattern_seq.sv
module tb_mem_pattern_seq;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        acc_valid = 1'b0;
    logic [1:0]  acc_kind = 2'd0;
    logic        refresh_req = 1'b0;
    logic        run_cmd = 1'b0;
    logic [5:0]  run_addr = 6'd0;
    logic        timeout = 1'b0;
    logic        wait_in = 1'b0;
    logic        host_we = 1'b0;
    logic [5:0]  host_addr = 6'd0;
    logic [31:0] host_wdata = 32'd0;
    logic [13:0] gpl;
    logic [7:0]  bsel;
    logic [7:0]  csel;
    logic        busy;
    logic        done;

    int checks = 0;
    int errors = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    mem_pattern_seq dut (
        .clk(clk), .rst_n(rst_n), .acc_valid(acc_valid), .acc_kind(acc_kind),
        .refresh_req(refresh_req), .run_cmd(run_cmd), .run_addr(run_addr),
        .timeout(timeout), .wait_in(wait_in), .host_we(host_we),
        .host_addr(host_addr), .host_wdata(host_wdata),
        .gpl(gpl), .bsel(bsel), .csel(csel), .busy(busy), .done(done)
    );

    // ---------------- behavioural reference model ----------------
    bit [31:0] m_mem [64];
    bit        m_busy, m_exc, m_done, m_s1, m_s2;
    int        m_ptr;
    bit [31:0] m_word;
    int        entry_tab [4] = '{'h00, 'h08, 'h18, 'h20};

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_busy = 0; m_exc = 0; m_done = 0; m_s1 = 0; m_s2 = 0;
            m_ptr = 0; m_word = 0;
        end else begin
            bit old_s2;
            old_s2 = m_s2;
            m_s2 = m_s1;
            m_s1 = wait_in;
            m_done = 0;
            if (!m_busy) begin
                int a;
                a = -1;
                if (refresh_req)    a = 'h30;
                else if (run_cmd)   a = int'(run_addr);
                else if (acc_valid) a = entry_tab[acc_kind];
                if (a >= 0) begin
                    m_ptr = a; m_word = m_mem[a]; m_busy = 1; m_exc = 0;
                end
                if (host_we) m_mem[host_addr] = host_wdata;
            end else begin
                if (timeout && !m_exc) begin
                    m_ptr = 'h3C; m_word = m_mem['h3C]; m_exc = 1;
                end else if (m_word[30] && old_s2) begin
                    // held
                end else if (m_word[31]) begin
                    m_busy = 0; m_done = 1; m_exc = 0;
                end else begin
                    m_ptr = (m_ptr + 1) % 64; m_word = m_mem[m_ptr];
                end
            end
        end
    end

    task automatic check(string tag, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h at %0t", tag, act, exp, $time);
        end
    endtask

    // cycle-by-cycle comparison against the model
    always @(negedge clk) begin
        if (rst_n) begin
            check(m_busy ? "R6 gpl" : "R1 gpl", int'(gpl), m_busy ? int'(m_word[13:0]) : 0);
            check(m_busy ? "R6 bsel" : "R1 bsel", int'(bsel), m_busy ? int'(m_word[21:14]) : 0);
            check(m_busy ? "R6 csel" : "R1 csel", int'(csel), m_busy ? int'(m_word[29:22]) : 0);
            check("R5 busy", int'(busy), int'(m_busy));
            check("R7 done", int'(done), int'(m_done));
        end
    end

    // ---------------- stimulus helpers ----------------
    function automatic bit [31:0] fill_word(int a);
        bit last, wt;
        last = (a == 'h01 || a == 'h0B || a == 'h18 || a == 'h23 || a == 'h31 || a == 'h3D);
        wt   = (a == 'h09);
        return {last, wt, ~8'(a), 2'(a), 6'(a), 14'(a)};
    endfunction

    task automatic host_write(int a, bit [31:0] d);
        @(negedge clk);
        host_we = 1; host_addr = 6'(a); host_wdata = d;
        @(negedge clk);
        host_we = 0;
    endtask

    task automatic start_acc(int k);
        @(negedge clk);
        acc_valid = 1; acc_kind = 2'(k);
        @(negedge clk);
        acc_valid = 0;
    endtask

    task automatic start_run(int a);
        @(negedge clk);
        run_cmd = 1; run_addr = 6'(a);
        @(negedge clk);
        run_cmd = 0;
    endtask

    task automatic wait_idle(string tag);
        for (int i = 0; i < 200 && busy; i++) @(negedge clk);
        check(tag, int'(done), 1);
        @(negedge clk);
        check("R7 done width", int'(done), 0);
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        errors++;
        $display("FAIL watchdog: actual hung expected finish");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        check("R1 busy", int'(busy), 0);
        check("R1 gpl", int'(gpl), 0);
        check("R1 done", int'(done), 0);
        rst_n = 1;
        for (int a = 0; a < 64; a++) host_write(a, fill_word(a));

        // R2: each access kind enters at its own address
        for (int k = 0; k < 4; k++) begin
            start_acc(k);
            check("R2 entry", int'(gpl), entry_tab[k]);
            wait_idle("R7 done after access");
        end

        // R3: refresh entry
        @(negedge clk); refresh_req = 1; @(negedge clk); refresh_req = 0;
        check("R3 refresh entry", int'(gpl), 'h30);
        wait_idle("R7 done after refresh");

        // R4 + R11: run command at any address, wrap past the top
        start_run('h3E);
        check("R4 run entry", int'(gpl), 'h3E);
        @(negedge clk); @(negedge clk);
        check("R11 wrap", int'(gpl), 'h00);
        wait_idle("R7 done after run");

        // R5: priority, and requests while busy are dropped
        @(negedge clk);
        refresh_req = 1; run_cmd = 1; run_addr = 6'h20; acc_valid = 1; acc_kind = 2'd1;
        @(negedge clk);
        refresh_req = 0; run_cmd = 0; acc_valid = 0;
        check("R5 refresh wins", int'(gpl), 'h30);
        @(negedge clk);
        run_cmd = 1; acc_valid = 1; acc_kind = 2'd0;
        @(negedge clk);
        run_cmd = 0; acc_valid = 0;
        wait_idle("R7 done after priority");
        check("R5 busy request dropped", int'(busy), 0);
        @(negedge clk); @(negedge clk); @(negedge clk);
        run_cmd = 1; acc_valid = 1; acc_kind = 2'd0; run_addr = 6'h18;
        @(negedge clk);
        run_cmd = 0; acc_valid = 0;
        check("R5 run beats access", int'(gpl), 'h18);
        wait_idle("R7 done after run priority");

        // R8: wait freeze on the wait-enabled word
        wait_in = 1;
        repeat (3) @(negedge clk);
        start_acc(1);
        check("R8 first word", int'(gpl), 'h08);
        @(negedge clk);
        check("R8 wait word", int'(gpl), 'h09);
        repeat (4) @(negedge clk);
        check("R8 held", int'(gpl), 'h09);
        wait_in = 0;
        @(negedge clk);
        @(negedge clk);
        check("R8 still held by sync", int'(gpl), 'h09);
        @(negedge clk);
        check("R8 released", int'(gpl), 'h0A);
        wait_idle("R7 done after wait");

        // R9: timeout preemption, ignored inside exception and when idle
        start_acc(1);
        timeout = 1;
        @(negedge clk);
        timeout = 0;
        check("R9 exception entry", int'(gpl), 'h3C);
        timeout = 1;
        @(negedge clk);
        timeout = 0;
        check("R9 ignored in exception", int'(gpl), 'h3D);
        wait_idle("R7 done after exception");
        timeout = 1;
        @(negedge clk);
        timeout = 0;
        @(negedge clk);
        check("R9 idle timeout ignored", int'(busy), 0);

        // R10: writes while busy are discarded, writes while idle land
        start_run('h19);
        host_write('h19, 32'h8000_00AA);
        wait_idle("R7 done R10 run");
        start_run('h19);
        check("R10 busy write discarded", int'(gpl), 'h19);
        wait_idle("R7 done R10 rerun");
        host_write('h19, 32'h8000_0055);
        start_run('h19);
        check("R10 idle write applied", int'(gpl), 'h55);
        wait_idle("R7 done R10 single");
        host_write('h19, fill_word('h19));

        repeat (3) @(negedge clk);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule